// File: doc/BRIEF.md
# Memory window address translator

This block holds the memory mapping state for one card socket: five windows, each described by a start page, a stop page and a translation offset, plus a shared enable byte. A host memory address is split into a 4 KB page number and a 12-bit byte offset. If the page falls inside an enabled window, the block reports a hit and the number of the window that matched. It also returns a card address, formed by adding the window's offset to the page and keeping the low 12 bits unchanged, together with the window's data-width, wait-state and memory-space attributes.

Software programs the windows one byte at a time through a simple write port. Each 16-bit window field is split into a low byte and a high byte. The high byte carries the top four page bits and the control attributes. The translation result is registered, so the result for a host address appears one clock after that address is presented.

Top module: `mw_xlate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every window is disabled, and xl_hit, xl_win, xl_card_addr and all attribute outputs are zero.
- R2: An enabled window matches when its start page <= host page <= its stop page, both bounds inclusive. The host page is host_addr[23:12]. xl_hit rises on the clock edge after the address is presented.
- R3: Window n can match only while bit n of the enable register is set. The enable register sits at register address 0x06.
- R4: On a hit, xl_card_addr[23:12] = (host page + window offset) mod 4096, and xl_card_addr[11:0] = host_addr[11:0].
- R5: When several enabled windows match, the lowest-numbered one is reported on xl_win and supplies the offset and the attributes.
- R6: A window whose stop page is below its start page never matches.
- R7: The reported attributes come from the high bytes of the matching window: xl_wide is start high byte bit 7, xl_wait is stop high byte bits 7:6, and xl_attr is offset high byte bit 6 (1 = attribute space, 0 = common space).
- R8: Window n's start, stop and offset fields sit at register addresses 0x10+8n, 0x12+8n and 0x14+8n, low byte first. Bits 3:0 of each high byte hold page bits 11:8. Writing one byte of a field leaves the other byte unchanged.
- R9: Writes to register addresses that hold no field (for example 0x16, 0x17 or 0x38 and above) change no window and no enable bit.
- R10: When no window matches, xl_card_addr, xl_win and all attribute outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_addr | input | 8 | Register address of the byte being written |
| cfg_wdata | input | 8 | Byte to write |
| host_addr | input | 24 | Host memory address to translate |
| xl_hit | output | 1 | An enabled window matched the previous address |
| xl_win | output | 3 | Number of the winning window |
| xl_card_addr | output | 24 | Translated card address |
| xl_wide | output | 1 | Winning window uses 16-bit data width |
| xl_wait | output | 2 | Wait-state selection of the winning window |
| xl_attr | output | 1 | Winning window targets attribute space |

## Verification
The assertions assume that host_addr and the register port change only between clock edges. They also assume that the enable register never has bits set above the number of windows. The range property is checked on window 0 only, and the priority property looks only at the case where window 0 matches. The bench keeps to these assumptions: it drives every input on the falling edge, writes the enable byte with the upper three bits clear, and samples results one full cycle after each address is presented. It programs overlapping, inverted, wrapping and single-page windows, so that each of these cases reaches the registered outputs.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int PG_SHIFT = 12;                  // 4 KB page granularity
    localparam int FIELD_W  = 12;                  // page field width
    localparam int HOST_AW  = FIELD_W + PG_SHIFT;  // host and card address width

    // bit positions of control attributes in the 16-bit field pairs
    localparam int WIDE_BIT = 15;   // start field
    localparam int WAIT_HI  = 15;   // stop field
    localparam int WAIT_LO  = 14;   // stop field
    localparam int ATTR_BIT = 14;   // offset field

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] stop;
        logic [15:0] ofs;
    } win_regs_t;

    typedef struct packed {
        logic       wide;
        logic [1:0] wait_sel;
        logic       attr;
    } win_attr_t;

    function automatic logic [FIELD_W-1:0] page_of(input logic [15:0] f);
        return f[FIELD_W-1:0];
    endfunction

    function automatic win_attr_t attr_of(input win_regs_t r);
        win_attr_t a;
        a.wide     = r.start[WIDE_BIT];
        a.wait_sel = r.stop[WAIT_HI:WAIT_LO];
        a.attr     = r.ofs[ATTR_BIT];
        return a;
    endfunction

endpackage

// File: rtl/mw_regfile.sv
module mw_regfile
    import mw_pkg::*;
#(
    parameter int         NWIN       = 5,
    parameter logic [7:0] REG_BASE   = 8'h10,
    parameter int         REG_STRIDE = 8,
    parameter logic [7:0] EN_ADDR    = 8'h06
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [7:0]             addr,
    input  logic [7:0]             wdata,
    output win_regs_t [NWIN-1:0]   regs,
    output logic      [NWIN-1:0]   win_en
);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [7:0] BASE = 8'(int'(REG_BASE) + REG_STRIDE * w);
        win_regs_t r_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (we) begin
                case (addr)
                    BASE:         r_q.start[7:0]  <= wdata;
                    BASE + 8'd1:  r_q.start[15:8] <= wdata;
                    BASE + 8'd2:  r_q.stop[7:0]   <= wdata;
                    BASE + 8'd3:  r_q.stop[15:8]  <= wdata;
                    BASE + 8'd4:  r_q.ofs[7:0]    <= wdata;
                    BASE + 8'd5:  r_q.ofs[15:8]   <= wdata;
                    default:      ;
                endcase
            end
        end

        assign regs[w] = r_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en <= '0;
        end else if (we && addr == EN_ADDR) begin
            win_en <= wdata[NWIN-1:0];
        end
    end

endmodule

// File: rtl/mw_window_cmp.sv
module mw_window_cmp
    import mw_pkg::*;
#(
    parameter int NWIN = 5
) (
    input  win_regs_t [NWIN-1:0] regs,
    input  logic      [NWIN-1:0] win_en,
    input  logic [FIELD_W-1:0]   host_page,
    output logic      [NWIN-1:0] match_vec
);

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [FIELD_W-1:0] lo_pg;
        logic [FIELD_W-1:0] hi_pg;
        assign lo_pg = page_of(regs[w].start);
        assign hi_pg = page_of(regs[w].stop);
        // an inverted window (hi < lo) cannot satisfy both bounds
        assign match_vec[w] = win_en[w] && (host_page >= lo_pg) && (host_page <= hi_pg);
    end

endmodule

// File: rtl/mw_prio_sel.sv
module mw_prio_sel
    import mw_pkg::*;
#(
    parameter  int NWIN  = 5,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic      [NWIN-1:0] match_vec,
    input  win_regs_t [NWIN-1:0] regs,
    input  logic [HOST_AW-1:0]   host_addr,
    output logic                 hit_q,
    output logic [IDX_W-1:0]     idx_q,
    output logic [HOST_AW-1:0]   card_q,
    output win_attr_t            attr_q
);

    logic [IDX_W-1:0]   sel;
    logic               any;
    win_regs_t          cur;
    logic [FIELD_W-1:0] card_pg;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                sel = IDX_W'(w);
                any = 1'b1;
            end
        end
    end

    assign cur     = regs[sel];
    assign card_pg = host_addr[HOST_AW-1:PG_SHIFT] + page_of(cur.ofs);

    always_ff @(posedge clk) begin
        if (rst || !any) begin
            hit_q  <= 1'b0;
            idx_q  <= '0;
            card_q <= '0;
            attr_q <= '0;
        end else begin
            hit_q  <= 1'b1;
            idx_q  <= sel;
            card_q <= {card_pg, host_addr[PG_SHIFT-1:0]};
            attr_q <= attr_of(cur);
        end
    end

endmodule

// File: rtl/mw_xlate.sv
module mw_xlate
    import mw_pkg::*;
#(
    parameter  int         NWIN       = 5,
    parameter  logic [7:0] REG_BASE   = 8'h10,
    parameter  int         REG_STRIDE = 8,
    parameter  logic [7:0] EN_ADDR    = 8'h06,
    localparam int         IDX_W      = $clog2(NWIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic [HOST_AW-1:0] host_addr,
    output logic               xl_hit,
    output logic [IDX_W-1:0]   xl_win,
    output logic [HOST_AW-1:0] xl_card_addr,
    output logic               xl_wide,
    output logic [1:0]         xl_wait,
    output logic               xl_attr
);

    win_regs_t [NWIN-1:0] regs;
    logic      [NWIN-1:0] win_en;
    logic      [NWIN-1:0] match_vec;
    win_attr_t            attr_q;

    mw_regfile #(
        .NWIN(NWIN), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE), .EN_ADDR(EN_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .regs(regs), .win_en(win_en)
    );

    mw_window_cmp #(.NWIN(NWIN)) u_cmp (
        .regs(regs), .win_en(win_en),
        .host_page(host_addr[HOST_AW-1:PG_SHIFT]),
        .match_vec(match_vec)
    );

    mw_prio_sel #(.NWIN(NWIN)) u_sel (
        .clk(clk), .rst(rst), .match_vec(match_vec), .regs(regs),
        .host_addr(host_addr),
        .hit_q(xl_hit), .idx_q(xl_win), .card_q(xl_card_addr), .attr_q(attr_q)
    );

    assign xl_wide = attr_q.wide;
    assign xl_wait = attr_q.wait_sel;
    assign xl_attr = attr_q.attr;

endmodule

// File: rtl/mw_xlate_chk.sv
module mw_xlate_chk
    import mw_pkg::*;
#(
    parameter  int NWIN  = 5,
    localparam int IDX_W = $clog2(NWIN)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [HOST_AW-1:0]   host_addr,
    input logic                 xl_hit,
    input logic [IDX_W-1:0]     xl_win,
    input logic [HOST_AW-1:0]   xl_card_addr,
    input logic                 xl_wide,
    input logic [1:0]           xl_wait,
    input logic                 xl_attr,
    input win_regs_t [NWIN-1:0] regs,
    input logic      [NWIN-1:0] win_en,
    input logic      [NWIN-1:0] match_vec
);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !xl_hit);

    p_match_hits_r2: assert property (@(posedge clk) disable iff (rst)
        (|match_vec) |=> xl_hit);

    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (win_en == '0) |=> !xl_hit);

    p_low_pass_r4: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> xl_card_addr[PG_SHIFT-1:0] == $past(host_addr[PG_SHIFT-1:0]));

    p_low_wins_r5: assert property (@(posedge clk) disable iff (rst)
        match_vec[0] |=> (xl_hit && xl_win == '0));

    p_win_range_r5: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> int'(xl_win) < NWIN);

    p_inverted_r6: assert property (@(posedge clk) disable iff (rst)
        (page_of(regs[0].stop) < page_of(regs[0].start)) |-> !match_vec[0]);

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !xl_hit |-> (xl_card_addr == '0 && xl_win == '0 && !xl_wide && xl_wait == 2'b00 && !xl_attr));

endmodule

bind mw_xlate mw_xlate_chk #(.NWIN(NWIN)) u_chk (
    .clk(clk), .rst(rst), .host_addr(host_addr),
    .xl_hit(xl_hit), .xl_win(xl_win), .xl_card_addr(xl_card_addr),
    .xl_wide(xl_wide), .xl_wait(xl_wait), .xl_attr(xl_attr),
    .regs(regs), .win_en(win_en), .match_vec(match_vec)
);

// File: tb/sim_mw_xlate.sv
`timescale 1ns/1ps
module sim_mw_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] host_addr = '0;
    logic        xl_hit;
    logic [2:0]  xl_win;
    logic [23:0] xl_card_addr;
    logic        xl_wide;
    logic [1:0]  xl_wait;
    logic        xl_attr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mw_xlate u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .host_addr(host_addr), .xl_hit(xl_hit), .xl_win(xl_win),
        .xl_card_addr(xl_card_addr), .xl_wide(xl_wide), .xl_wait(xl_wait), .xl_attr(xl_attr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int n, input logic [11:0] s, input logic [11:0] e, input logic [11:0] o,
                           input logic wide, input logic [1:0] wt, input logic at);
        logic [7:0] b;
        b = 8'(8'h10 + 8 * n);
        wr(b,        s[7:0]);
        wr(b + 8'd1, {wide, 3'b000, s[11:8]});
        wr(b + 8'd2, e[7:0]);
        wr(b + 8'd3, {wt, 2'b00, e[11:8]});
        wr(b + 8'd4, o[7:0]);
        wr(b + 8'd5, {1'b0, at, 2'b00, o[11:8]});
    endtask

    function automatic logic [23:0] xl(input logic [23:0] a, input logic [11:0] o);
        logic [11:0] pg;
        pg = a[23:12] + o;
        return {pg, a[11:0]};
    endfunction

    // present an address, then sample one full cycle later
    task automatic probe(input string req, input logic [23:0] a, input logic eh,
                         input logic [2:0] ew, input logic [23:0] ec);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        chk(req, "hit", 32'(xl_hit), 32'(eh));
        chk(req, "win", 32'(xl_win), 32'(ew));
        chk(req, "card", 32'(xl_card_addr), 32'(ec));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "hit in reset", 32'(xl_hit), 0);
        chk("R1", "card in reset", 32'(xl_card_addr), 0);
        rst = 1'b0;
        host_addr = 24'h000123;
        @(negedge clk);
        chk("R1", "hit after reset", 32'(xl_hit), 0);
        chk("R1", "attr after reset", 32'({xl_wide, xl_wait, xl_attr}), 0);
        probe("R10", 24'h000123, 0, 0, 0);
    endtask

    task automatic t_basic;
        set_win(1, 12'h010, 12'h01F, 12'h200, 0, 2'b00, 0);
        probe("R3", 24'h010ABC, 0, 0, 0);          // still disabled
        wr(8'h06, 8'h02);
        probe("R2", 24'h010ABC, 1, 1, xl(24'h010ABC, 12'h200));
        probe("R2", 24'h01FFFF, 1, 1, xl(24'h01FFFF, 12'h200));
        probe("R2", 24'h020000, 0, 0, 0);
        probe("R2", 24'h00FFFF, 0, 0, 0);
        probe("R4", 24'h015001, 1, 1, 24'h215001);
    endtask

    task automatic t_enable;
        wr(8'h06, 8'h00);
        probe("R3", 24'h010ABC, 0, 0, 0);
        wr(8'h06, 8'h02);
        probe("R3", 24'h010ABC, 1, 1, 24'h210ABC);
    endtask

    task automatic t_wrap;
        set_win(0, 12'hF00, 12'hFFF, 12'h200, 0, 2'b00, 0);
        wr(8'h06, 8'h03);
        probe("R4", 24'hF80123, 1, 0, 24'h180123);
        probe("R4", 24'hFFFFFF, 1, 0, 24'h1FFFFF);
    endtask

    task automatic t_prio;
        set_win(2, 12'h300, 12'h3FF, 12'h001, 0, 2'b00, 0);
        set_win(4, 12'h300, 12'h3FF, 12'h002, 0, 2'b00, 0);
        wr(8'h06, 8'h14);
        probe("R5", 24'h345678, 1, 2, 24'h346678);
        wr(8'h06, 8'h10);
        probe("R5", 24'h345678, 1, 4, 24'h347678);
    endtask

    task automatic t_inverted;
        set_win(3, 12'h500, 12'h4FF, 12'h010, 0, 2'b00, 0);
        wr(8'h06, 8'h08);
        probe("R6", 24'h500000, 0, 0, 0);
        probe("R6", 24'h4FF000, 0, 0, 0);
        set_win(3, 12'h500, 12'h500, 12'h010, 0, 2'b00, 0);
        probe("R2", 24'h500FFF, 1, 3, 24'h510FFF);
        probe("R2", 24'h501000, 0, 0, 0);
    endtask

    task automatic t_attr;
        set_win(0, 12'h700, 12'h70F, 12'h000, 1, 2'b10, 1);
        wr(8'h06, 8'h01);
        probe("R7", 24'h700010, 1, 0, 24'h700010);
        chk("R7", "wide", 32'(xl_wide), 1);
        chk("R7", "wait", 32'(xl_wait), 2);
        chk("R7", "attr", 32'(xl_attr), 1);
        probe("R10", 24'h710000, 0, 0, 0);
        chk("R10", "attrs on miss", 32'({xl_wide, xl_wait, xl_attr}), 0);
    endtask

    task automatic t_byte;
        // window 1 was 0x010..0x01F with offset 0x200; change only the start low byte
        wr(8'h06, 8'h02);
        wr(8'h18, 8'h18);
        probe("R8", 24'h017000, 0, 0, 0);
        probe("R8", 24'h018000, 1, 1, 24'h218000);
        // change only the offset high byte: page bits 11:8 become 3
        wr(8'h1D, 8'h03);
        probe("R8", 24'h01A004, 1, 1, 24'h31A004);
    endtask

    task automatic t_unmapped;
        wr(8'h16, 8'hFF);
        wr(8'h17, 8'hFF);
        wr(8'h38, 8'hFF);
        wr(8'h3F, 8'hFF);
        wr(8'h07, 8'hFF);
        wr(8'h00, 8'hFF);
        probe("R9", 24'h01A004, 1, 1, 24'h31A004);
        probe("R9", 24'h020000, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_enable();
        t_wrap();
        t_prio();
        t_inverted();
        t_attr();
        t_byte();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule